// File: doc/BRIEF.md
# Audio master clock frame generator

This block turns a single master clock into the timing skeleton of a two-channel serial audio frame. It counts master-clock cycles into bit periods and bit periods into frames. From these counts it produces a frame-clock level, one-cycle strobes that mark where the bit clock rises and falls, a bit-clock level, a frame-sync level, a bit index inside the current channel half, and a strobe that starts a conversion at the top of every frame. The serializer and the converter core consume these signals as clock enables, so the whole datapath stays on the master clock.

A clock-ratio input selects 256 or 384 master clocks per frame. A 3-bit serial-mode input selects 64 or 32 bit clocks per frame. The generator only runs when the serial mode is one of the master modes (3 to 7) and the run input is high. Otherwise every output stays idle, and the counters wait at the start of the left half. The mode, ratio and run inputs are registered once, so the first frame begins one master clock after run is sampled high.

Top module: `afg_frame_gen`

## Requirements
- R1: While reset is asserted, or on the master clock after run is sampled low, all outputs are low and bit_idx is 0.
- R2: Serial-mode values 0, 1 and 2 are treated as slave modes. In those modes all outputs stay idle (low, bit_idx 0) even with run high.
- R3: One frame (one full frame_clk period) lasts 256 master clocks when ratio_long is 0, and 384 master clocks when it is 1.
- R4: Serial modes 3, 4 and 5 give 64 bit periods per frame. Modes 6 and 7 give 32. One bit period is therefore 4, 6, 8 or 12 master clocks.
- R5: bclk_fall is high for one master clock on the first cycle of each bit period. bclk_rise is high for one master clock on cycle P/2 of the period, where P is the period length. bclk is high from cycle P/2 to the end of the period.
- R6: frame_clk is high during the first half of the frame's bit periods (left channel) and low during the second half (right channel). It changes only in cycles where bclk_fall is high.
- R7: bit_idx counts 0 to N/2-1 inside each half, where N is the number of bits per frame. It advances on each bclk_fall and returns to 0 at the start of each half.
- R8: conv_start is high for exactly the one master clock in which frame_clk rises. The first such cycle is the master clock right after run is sampled high in a master mode.
- R9: fsync is high during the first bit period of each half (bit_idx 0 while running) and low otherwise.
- R10: Dropping run mid-frame returns the generator to idle. Raising run again restarts at bit 0 of the left half, with a fresh conv_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables frame generation |
| ratio_long | input | 1 | 0: 256 master clocks per frame, 1: 384 |
| serial_mode | input | 3 | 0-2 slave (idle), 3-5 64 bits per frame, 6-7 32 bits per frame |
| frame_clk | output | 1 | Frame clock level, high for left half |
| bclk | output | 1 | Bit-clock level |
| bclk_rise | output | 1 | One-cycle strobe at bit-clock rising edge |
| bclk_fall | output | 1 | One-cycle strobe at bit-clock falling edge |
| fsync | output | 1 | High during first bit period of each half |
| conv_start | output | 1 | One-cycle strobe at each frame-clock rising edge |
| bit_idx | output | 5 | Bit index within the current half |

## Verification
The bench runs all four period lengths (4, 6, 8, 12 master clocks) across more than one frame each. A divider that wrapped one cycle early or late would then drift against the modelled bclk_fall, bclk_rise and frame_clk positions. The half-frame boundary is checked at both 32 and 16 bits per half. A design that split the half at the wrong count, or did not clear bit_idx there, would show a wrong frame_clk or bit_idx at that cycle. Slave modes are driven with run high to catch a generator that decodes only run. A run drop in the middle of a frame, followed by a restart, catches counters that resume where they stopped instead of restarting at the top of the left half.

// File: rtl/afg_pkg.sv
package afg_pkg;

    typedef enum logic [2:0] {
        SM_SLAVE_A   = 3'd0,
        SM_SLAVE_B   = 3'd1,
        SM_SLAVE_C   = 3'd2,
        SM_WIDE_DLY  = 3'd3,
        SM_WIDE_MSB  = 3'd4,
        SM_WIDE_LSB  = 3'd5,
        SM_NARR_MSB  = 3'd6,
        SM_NARR_LSB  = 3'd7
    } serial_mode_e;

    typedef struct packed {
        logic master;
        logic narrow;
        logic long_frame;
    } frame_sel_t;

    function automatic logic mode_is_master(input logic [2:0] mode);
        return mode >= 3'(SM_WIDE_DLY);
    endfunction

    function automatic logic mode_is_narrow(input logic [2:0] mode);
        return (mode == 3'(SM_NARR_MSB)) || (mode == 3'(SM_NARR_LSB));
    endfunction

    function automatic frame_sel_t decode_sel(input logic [2:0] mode,
                                              input logic       ratio_long);
        frame_sel_t s;
        s.master     = mode_is_master(mode);
        s.narrow     = mode_is_narrow(mode);
        s.long_frame = ratio_long;
        return s;
    endfunction

endpackage

// File: rtl/afg_mode_decode.sv
module afg_mode_decode
    import afg_pkg::*;
#(
    parameter int unsigned FRAME_SHORT = 256,
    parameter int unsigned FRAME_LONG  = 384,
    parameter int unsigned BITS_WIDE   = 64,
    parameter int unsigned BITS_NARROW = 32,
    parameter int unsigned PER_W       = 4,
    parameter int unsigned BIT_W       = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ratio_long,
    input  logic [2:0]       serial_mode,
    output logic             active,
    output logic [PER_W-1:0] per_last,
    output logic [PER_W-1:0] per_mid,
    output logic [BIT_W-1:0] bit_last,
    output logic [BIT_W-1:0] half_bits
);

    localparam logic [PER_W-1:0] LAST_SW = PER_W'(FRAME_SHORT / BITS_WIDE - 1);
    localparam logic [PER_W-1:0] LAST_LW = PER_W'(FRAME_LONG / BITS_WIDE - 1);
    localparam logic [PER_W-1:0] LAST_SN = PER_W'(FRAME_SHORT / BITS_NARROW - 1);
    localparam logic [PER_W-1:0] LAST_LN = PER_W'(FRAME_LONG / BITS_NARROW - 1);
    localparam logic [PER_W-1:0] MID_SW  = PER_W'(FRAME_SHORT / BITS_WIDE / 2);
    localparam logic [PER_W-1:0] MID_LW  = PER_W'(FRAME_LONG / BITS_WIDE / 2);
    localparam logic [PER_W-1:0] MID_SN  = PER_W'(FRAME_SHORT / BITS_NARROW / 2);
    localparam logic [PER_W-1:0] MID_LN  = PER_W'(FRAME_LONG / BITS_NARROW / 2);

    frame_sel_t             sel;
    logic [PER_W-1:0]       last_d;
    logic [PER_W-1:0]       mid_d;

    always_comb begin
        sel = decode_sel(serial_mode, ratio_long);
        unique case ({sel.narrow, sel.long_frame})
            2'b00:   begin last_d = LAST_SW; mid_d = MID_SW; end
            2'b01:   begin last_d = LAST_LW; mid_d = MID_LW; end
            2'b10:   begin last_d = LAST_SN; mid_d = MID_SN; end
            default: begin last_d = LAST_LN; mid_d = MID_LN; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            per_last  <= LAST_SW;
            per_mid   <= MID_SW;
            bit_last  <= BIT_W'(BITS_WIDE - 1);
            half_bits <= BIT_W'(BITS_WIDE / 2);
        end else begin
            active    <= run && sel.master;
            per_last  <= last_d;
            per_mid   <= mid_d;
            bit_last  <= sel.narrow ? BIT_W'(BITS_NARROW - 1) : BIT_W'(BITS_WIDE - 1);
            half_bits <= sel.narrow ? BIT_W'(BITS_NARROW / 2) : BIT_W'(BITS_WIDE / 2);
        end
    end

endmodule

// File: rtl/afg_bit_divider.sv
module afg_bit_divider #(
    parameter int unsigned PER_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [PER_W-1:0] per_last,
    input  logic [PER_W-1:0] per_mid,
    output logic             tick_fall,
    output logic             tick_rise,
    output logic             bclk_lvl,
    output logic             period_end
);

    logic [PER_W-1:0] mcnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            mcnt <= '0;
        end else if (mcnt >= per_last) begin
            mcnt <= '0;
        end else begin
            mcnt <= mcnt + 1'b1;
        end
    end

    always_comb begin
        tick_fall  = active && (mcnt == '0);
        tick_rise  = active && (mcnt == per_mid);
        bclk_lvl   = active && (mcnt >= per_mid);
        period_end = active && (mcnt >= per_last);
    end

endmodule

// File: rtl/afg_frame_counter.sv
module afg_frame_counter #(
    parameter int unsigned BIT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             period_end,
    input  logic [BIT_W-1:0] bit_last,
    output logic [BIT_W-1:0] bcnt
);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            bcnt <= '0;
        end else if (period_end) begin
            if (bcnt >= bit_last) begin
                bcnt <= '0;
            end else begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/afg_frame_gen.sv
module afg_frame_gen #(
    parameter int unsigned FRAME_SHORT = 256,
    parameter int unsigned FRAME_LONG  = 384,
    parameter int unsigned BITS_WIDE   = 64,
    parameter int unsigned BITS_NARROW = 32,
    localparam int unsigned PER_MAX    = FRAME_LONG / BITS_NARROW,
    localparam int unsigned PER_W      = $clog2(PER_MAX + 1),
    localparam int unsigned BIT_W      = $clog2(BITS_WIDE),
    localparam int unsigned IDX_W      = BIT_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             ratio_long,
    input  logic [2:0]       serial_mode,
    output logic             frame_clk,
    output logic             bclk,
    output logic             bclk_rise,
    output logic             bclk_fall,
    output logic             fsync,
    output logic             conv_start,
    output logic [IDX_W-1:0] bit_idx
);

    logic             active;
    logic [PER_W-1:0] per_last;
    logic [PER_W-1:0] per_mid;
    logic [BIT_W-1:0] bit_last;
    logic [BIT_W-1:0] half_bits;
    logic             tick_fall;
    logic             tick_rise;
    logic             bclk_lvl;
    logic             period_end;
    logic [BIT_W-1:0] bcnt;
    logic             left_half;
    logic [BIT_W-1:0] idx_full;

    afg_mode_decode #(
        .FRAME_SHORT(FRAME_SHORT),
        .FRAME_LONG (FRAME_LONG),
        .BITS_WIDE  (BITS_WIDE),
        .BITS_NARROW(BITS_NARROW),
        .PER_W      (PER_W),
        .BIT_W      (BIT_W)
    ) u_decode (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ratio_long (ratio_long),
        .serial_mode(serial_mode),
        .active     (active),
        .per_last   (per_last),
        .per_mid    (per_mid),
        .bit_last   (bit_last),
        .half_bits  (half_bits)
    );

    afg_bit_divider #(
        .PER_W(PER_W)
    ) u_div (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .per_last  (per_last),
        .per_mid   (per_mid),
        .tick_fall (tick_fall),
        .tick_rise (tick_rise),
        .bclk_lvl  (bclk_lvl),
        .period_end(period_end)
    );

    afg_frame_counter #(
        .BIT_W(BIT_W)
    ) u_frame (
        .clk       (clk),
        .rst       (rst),
        .active    (active),
        .period_end(period_end),
        .bit_last  (bit_last),
        .bcnt      (bcnt)
    );

    always_comb begin
        left_half  = bcnt < half_bits;
        idx_full   = left_half ? bcnt : (bcnt - half_bits);
        frame_clk  = active && left_half;
        bclk       = bclk_lvl;
        bclk_rise  = tick_rise;
        bclk_fall  = tick_fall;
        bit_idx    = active ? idx_full[IDX_W-1:0] : '0;
        fsync      = active && (idx_full == '0);
        conv_start = tick_fall && (bcnt == '0);
    end

endmodule

// File: rtl/afg_frame_gen_chk.sv
module afg_frame_gen_chk #(
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic [2:0]       serial_mode,
    input logic             frame_clk,
    input logic             bclk,
    input logic             bclk_rise,
    input logic             bclk_fall,
    input logic             fsync,
    input logic             conv_start,
    input logic [IDX_W-1:0] bit_idx
);

    assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!frame_clk && !bclk && !bclk_rise && !bclk_fall &&
                  !fsync && !conv_start && bit_idx == '0));

    assert_slave_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (serial_mode < 3'd3) |=> (!bclk_rise && !bclk_fall && !frame_clk));

    assert_strobes_apart_R5: assert property (@(posedge clk) disable iff (rst)
        !(bclk_rise && bclk_fall));

    assert_fclk_rise_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_clk) |-> bclk_fall);

    assert_fclk_fall_on_fall_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(frame_clk) |-> (bclk_fall || !fsync));

    assert_conv_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        conv_start == $rose(frame_clk));

    assert_conv_frame_top_R9: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> (fsync && bit_idx == '0 && bclk_fall));

endmodule

bind afg_frame_gen afg_frame_gen_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .serial_mode(serial_mode),
    .frame_clk  (frame_clk),
    .bclk       (bclk),
    .bclk_rise  (bclk_rise),
    .bclk_fall  (bclk_fall),
    .fsync      (fsync),
    .conv_start (conv_start),
    .bit_idx    (bit_idx)
);

// File: tb/tb_afg_frame_gen.sv
module tb_afg_frame_gen;

    typedef struct {
        logic       fclk;
        logic       bclk;
        logic       rise;
        logic       fall;
        logic       fs;
        logic       cs;
        logic [4:0] idx;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run = 1'b0;
    logic       ratio_long = 1'b0;
    logic [2:0] serial_mode = 3'd0;
    logic       frame_clk, bclk, bclk_rise, bclk_fall, fsync, conv_start;
    logic [4:0] bit_idx;

    int n_tests = 0;
    int n_fail  = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    afg_frame_gen dut (
        .clk        (clk),
        .rst        (rst),
        .run        (run),
        .ratio_long (ratio_long),
        .serial_mode(serial_mode),
        .frame_clk  (frame_clk),
        .bclk       (bclk),
        .bclk_rise  (bclk_rise),
        .bclk_fall  (bclk_fall),
        .fsync      (fsync),
        .conv_start (conv_start),
        .bit_idx    (bit_idx)
    );

    function automatic exp_t model(input logic on, input logic lng,
                                   input logic [2:0] mode, input int t,
                                   input string tag);
        exp_t e;
        int nb, per, m, b, half;
        e.tag = tag;
        if (!on || mode < 3) begin
            e.fclk = 0; e.bclk = 0; e.rise = 0; e.fall = 0;
            e.fs = 0; e.cs = 0; e.idx = 0;
            return e;
        end
        nb   = (mode >= 6) ? 32 : 64;
        per  = (lng ? 384 : 256) / nb;
        half = nb / 2;
        m    = t % per;
        b    = (t / per) % nb;
        e.fclk = (b < half);
        e.bclk = (m >= per / 2);
        e.rise = (m == per / 2);
        e.fall = (m == 0);
        e.idx  = 5'(b % half);
        e.fs   = ((b % half) == 0);
        e.cs   = (m == 0) && (b == 0);
        return e;
    endfunction

    task automatic cmp1(input string tag, input string what,
                        input int act, input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     tag, what, act, exp, $time);
            bad = 1'b1;
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 1'b0;
            n_tests++;
            cmp1(e.tag, "frame_clk",  int'(frame_clk),  int'(e.fclk), bad);
            cmp1(e.tag, "bclk",       int'(bclk),       int'(e.bclk), bad);
            cmp1(e.tag, "bclk_rise",  int'(bclk_rise),  int'(e.rise), bad);
            cmp1(e.tag, "bclk_fall",  int'(bclk_fall),  int'(e.fall), bad);
            cmp1(e.tag, "fsync",      int'(fsync),      int'(e.fs),   bad);
            cmp1(e.tag, "conv_start", int'(conv_start), int'(e.cs),   bad);
            cmp1(e.tag, "bit_idx",    int'(bit_idx),    int'(e.idx),  bad);
            if (bad) n_fail++;
        end
    end

    task automatic drive(input logic on, input logic lng, input logic [2:0] mode,
                         input int n, input string tag);
        @(negedge clk);
        run = on; ratio_long = lng; serial_mode = mode;
        @(posedge clk);
        for (int t = 0; t < n; t++) q.push_back(model(on, lng, mode, t, tag));
        wait (q.size() == 0);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        n_fail++;
        n_tests++;
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        n_tests++;
        if ({frame_clk, bclk, bclk_rise, bclk_fall, fsync, conv_start} != 6'b0 || bit_idx != 0) begin
            $display("FAIL R1 reset: actual %b/%0d expected 000000/0",
                     {frame_clk, bclk, bclk_rise, bclk_fall, fsync, conv_start}, bit_idx);
            n_fail++;
        end
        rst = 1'b0;
        drive(1'b0, 1'b0, 3'd3, 20, "R1 idle");
        drive(1'b1, 1'b0, 3'd3, 600, "R3 R4 R5 R6 R7 R8 R9 short wide");
        drive(1'b0, 1'b0, 3'd3, 8, "R1 stop");
        drive(1'b1, 1'b1, 3'd4, 800, "R3 R4 R5 R6 R7 R8 R9 long wide");
        drive(1'b0, 1'b0, 3'd4, 8, "R1 stop");
        drive(1'b1, 1'b0, 3'd7, 600, "R3 R4 R5 R6 R7 R9 short narrow");
        drive(1'b0, 1'b0, 3'd7, 8, "R1 stop");
        drive(1'b1, 1'b1, 3'd6, 800, "R3 R4 R5 R6 R7 R9 long narrow");
        drive(1'b0, 1'b0, 3'd6, 8, "R1 stop");
        drive(1'b1, 1'b1, 3'd5, 420, "R4 R5 R8 long wide lsb");
        drive(1'b1, 1'b0, 3'd1, 100, "R2 slave mode 1");
        drive(1'b1, 1'b1, 3'd0, 60, "R2 slave mode 0");
        drive(1'b1, 1'b0, 3'd2, 60, "R2 slave mode 2");
        drive(1'b0, 1'b0, 3'd3, 8, "R1 stop");
        drive(1'b1, 1'b0, 3'd3, 150, "R10 first run");
        drive(1'b0, 1'b0, 3'd3, 10, "R10 R1 dropped");
        drive(1'b1, 1'b0, 3'd3, 300, "R10 restart");
        drive(1'b0, 1'b0, 3'd3, 8, "R1 final stop");
        summary();
    end

endmodule